// File: doc/BRIEF.md
# Receive frame-alignment delay FIFO

This block sits between a line-side receive channel and a PCM-side receive interface. Serial payload bits that arrive from the line are held in a small bit-wide FIFO. The PCM receive frame is not started when the FIFO reaches some fill level. It is started a programmable number of receive bit periods after the line receive frame boundary. This fixes the phase between the two 6 ms frames, whatever the FIFO contents happen to be.

A frame strobe from the line side restarts a delay counter. The counter advances only on cycles that carry the receive bit-clock enable. When the count reaches the programmed water level plus one, the block emits a one-cycle PCM frame start. From that cycle on, the read side pops one bit per bit-clock enable. The water level is a 10-bit value held in two register fields: a low byte and a 2-bit high part. Occupancy has a hard ceiling of 185 bits. A write that would cross the ceiling is dropped and recorded in a sticky overflow flag. A read from an empty FIFO returns a 1 and is recorded in a sticky underflow flag.

Top module: `rx_frame_align`

## Requirements
- R1: After reset `pcm_sof`, `dout_vld`, `ovf_flag` and `udf_flag` are 0 and `dout` is 1.
- R2: The water level WL is `{wl_hi, wl_lo}`, with `wl_hi` as bits 9:8. `pcm_sof` is high for the cycle that follows the (WL+1)-th `bit_en` clock edge after the clock edge that samples `line_sof`. This gives delays of 1 to 1024 bits.
- R3: A water level of zero gives a delay of exactly one bit period.
- R4: Cycles with `bit_en` low do not advance the delay, and a `bit_en` that coincides with `line_sof` is not counted.
- R5: A `line_sof` restarts a delay count already in progress. Each frame gives exactly one `pcm_sof`, and it is one cycle wide.
- R6: A bit is written when `bit_en` and `din_vld` are both high. Reading is released at the `pcm_sof` cycle and continues for good afterwards, popping one bit per `bit_en`. Bits leave in the order they were written, with `dout_vld` high in the cycle after each read.
- R7: Occupancy never exceeds 185 bits. A write that would exceed it is discarded, and the bits already stored are kept unchanged.
- R8: `ovf_flag` is set by a discarded write and cleared by a one on `ovf_clr`. A set and a clear in the same cycle leave the flag set.
- R9: A read while the FIFO is empty gives `dout` = 1 with `dout_vld` = 1, and sets `udf_flag`, which holds until reset.
- R10: No read occurs after reset until the first `pcm_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Receive bit-clock enable, one per bit period |
| line_sof | input | 1 | Line-side receive frame start strobe |
| din | input | 1 | Serial payload bit from the line side |
| din_vld | input | 1 | Payload bit present on `din` |
| wl_lo | input | 8 | Water level bits 7:0 |
| wl_hi | input | 2 | Water level bits 9:8 |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| pcm_sof | output | 1 | One-cycle PCM receive frame start |
| dout | output | 1 | Serial payload bit to the PCM side |
| dout_vld | output | 1 | `dout` carries a popped bit |
| ovf_flag | output | 1 | Sticky occupancy-ceiling overflow |
| udf_flag | output | 1 | Sticky read-while-empty underflow |

## Verification
The delay path is driven with water levels that set only low-byte bits, only high-part bits and all bits. Each level is combined with bit-enable patterns that are dense or sparse. This separates counting of enable edges from counting of clock cycles, and it catches a wrong join of the two register fields or an off-by-one at zero and at 1024. One sequence re-strobes the frame in the middle of a count, with the enable active on the strobe cycle, to tell a true restart from a continued count. A continuous stream against a steady water level checks the bit order. A long fill with the read side held off drives the ceiling, the dropped writes and the flag set/clear race. The drain that follows runs into the underflow fill value.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
   localparam int unsigned RXA_LO_W = 8;
   typedef struct packed {
      logic vld;
      logic data;
   } rxa_bit_t;
endpackage

// File: rtl/rxa_delay_ctr.sv
module rxa_delay_ctr #(
   parameter int unsigned WL_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_en,
   input  logic            line_sof,
   input  logic [WL_W-1:0] wl,
   output logic            sof_o
);
   logic [WL_W-1:0] cnt_q;
   logic            armed_q;
   logic            sof_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         sof_q   <= 1'b0;
      end else begin
         sof_q <= 1'b0;
         if (line_sof) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
         end else if (bit_en && armed_q) begin
            if (cnt_q == wl) begin
               armed_q <= 1'b0;
               sof_q   <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign sof_o = sof_q;

   // R4
   sof_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof_o |-> $past(bit_en) && !$past(line_sof));
   // R5
   sof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof_o |=> !sof_o);
endmodule

// File: rtl/rxa_bit_fifo.sv
module rxa_bit_fifo
   import rxa_pkg::*;
#(
   parameter int unsigned DEPTH   = 256,
   parameter int unsigned OCC_MAX = 185,
   parameter bit          FILL    = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_req,
   input  logic     wr_bit,
   input  logic     rd_req,
   output rxa_bit_t rd_out,
   output logic     wr_drop,
   output logic     rd_starved
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned OW = $clog2(DEPTH + 1);
   localparam logic [OW-1:0] CAP = OW'(OCC_MAX);

   logic            mem [DEPTH];
   logic [AW-1:0]   wp_q, rp_q, wp_n, rp_n;
   logic [OW-1:0]   occ_q;
   logic            empty, at_cap, rd_hit, wr_ok;
   rxa_bit_t        out_q;

   assign empty      = (occ_q == '0);
   assign at_cap     = (occ_q == CAP);
   assign rd_hit     = rd_req && !empty;
   assign wr_ok      = wr_req && (!at_cap || rd_hit);
   assign wr_drop    = wr_req && !wr_ok;
   assign rd_starved = rd_req && empty;

   generate
      if (DEPTH == (1 << AW)) begin : g_wrap_pow2
         assign wp_n = wp_q + 1'b1;
         assign rp_n = rp_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp_q] <= wr_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         occ_q <= '0;
         out_q <= '{vld: 1'b0, data: FILL};
      end else begin
         if (wr_ok)  wp_q <= wp_n;
         if (rd_hit) rp_q <= rp_n;
         occ_q     <= occ_q + OW'(wr_ok) - OW'(rd_hit);
         out_q.vld <= rd_req;
         if (rd_req) out_q.data <= rd_hit ? mem[rp_q] : FILL;
      end
   end

   assign rd_out = out_q;

   // R7
   occ_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= CAP);
   // R7
   drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_drop |=> $stable(occ_q) && $stable(wp_q));
   // R9
   starve_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_starved |=> rd_out.vld && (rd_out.data == FILL));
endmodule

// File: rtl/rxa_flags.sv
module rxa_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_set,
   input  logic ovf_clr,
   input  logic udf_set,
   output logic ovf_flag,
   output logic udf_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         udf_flag <= 1'b0;
      end else begin
         ovf_flag <= ovf_set | (ovf_flag & ~ovf_clr);
         udf_flag <= udf_flag | udf_set;
      end
   end

   // R8
   ovf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> ovf_flag);
   // R8
   ovf_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(ovf_set));
   // R9
   udf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      udf_flag |=> udf_flag);
endmodule

// File: rtl/rx_frame_align.sv
module rx_frame_align
   import rxa_pkg::*;
#(
   parameter int unsigned WL_W    = 10,
   parameter int unsigned DEPTH   = 256,
   parameter int unsigned OCC_MAX = 185,
   parameter bit          FILL    = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bit_en,
   input  logic                       line_sof,
   input  logic                       din,
   input  logic                       din_vld,
   input  logic [RXA_LO_W-1:0]        wl_lo,
   input  logic [WL_W-RXA_LO_W-1:0]   wl_hi,
   input  logic                       ovf_clr,
   output logic                       pcm_sof,
   output logic                       dout,
   output logic                       dout_vld,
   output logic                       ovf_flag,
   output logic                       udf_flag
);
   localparam int unsigned HI_W = WL_W - RXA_LO_W;

   generate
      if (WL_W <= RXA_LO_W) begin : g_bad_wl
         $error("WL_W must be wider than the low register byte");
      end
      if (OCC_MAX >= DEPTH || OCC_MAX == 0) begin : g_bad_cap
         $error("OCC_MAX must lie in 1..DEPTH-1");
      end
   endgenerate

   logic [WL_W-1:0] wl;
   logic            rd_run_q, rd_req;
   logic            drop, starved;
   rxa_bit_t        rd_out;

   assign wl = {wl_hi[HI_W-1:0], wl_lo};

   rxa_delay_ctr #(.WL_W(WL_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_sof(line_sof),
      .wl(wl), .sof_o(pcm_sof));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_run_q <= 1'b0;
      else if (pcm_sof) rd_run_q <= 1'b1;
   end

   assign rd_req = bit_en && (rd_run_q || pcm_sof);

   rxa_bit_fifo #(.DEPTH(DEPTH), .OCC_MAX(OCC_MAX), .FILL(FILL)) u_fifo (
      .clk(clk), .rst_n(rst_n), .wr_req(bit_en && din_vld), .wr_bit(din),
      .rd_req(rd_req), .rd_out(rd_out), .wr_drop(drop), .rd_starved(starved));

   rxa_flags u_flags (
      .clk(clk), .rst_n(rst_n), .ovf_set(drop), .ovf_clr(ovf_clr),
      .udf_set(starved), .ovf_flag(ovf_flag), .udf_flag(udf_flag));

   assign dout     = rd_out.data;
   assign dout_vld = rd_out.vld;

   // R10
   read_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> $past(rd_run_q || pcm_sof));
   // R6
   read_per_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> $past(bit_en));
endmodule

// File: tb/sim_rx_frame_align.sv
module sim_rx_frame_align;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bit_en = 0, line_sof = 0, din = 0, din_vld = 0, ovf_clr = 0;
   logic [7:0] wl_lo = '0;
   logic [1:0] wl_hi = '0;
   logic pcm_sof, dout, dout_vld, ovf_flag, udf_flag;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   rx_frame_align u0 (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_sof(line_sof),
      .din(din), .din_vld(din_vld), .wl_lo(wl_lo), .wl_hi(wl_hi), .ovf_clr(ovf_clr),
      .pcm_sof(pcm_sof), .dout(dout), .dout_vld(dout_vld), .ovf_flag(ovf_flag),
      .udf_flag(udf_flag));

   // delay vectors: water level, bit_en spacing, expected bit count
   localparam int NV = 8;
   localparam int VEC_WL  [NV] = '{0, 1, 5, 255, 256, 512, 1023, 0};
   localparam int VEC_GAP [NV] = '{1, 1, 2, 3, 1, 1, 1, 4};
   localparam int VEC_EXP [NV] = '{1, 2, 6, 256, 257, 513, 1024, 1};

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic pat(input int i);
      return ((i * 5 + i / 3) % 7) < 3;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; bit_en = 0; line_sof = 0; din_vld = 0; ovf_clr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic set_wl(input int wl);
      wl_lo = wl[7:0];
      wl_hi = wl[9:8];
   endtask

   // strobe a frame, then count bit_en edges until pcm_sof shows
   task automatic measure(input int wl, input int gap, input bit be_on_sof,
                          output int n, output int wide);
      bit found = 0;
      set_wl(wl);
      @(negedge clk);
      line_sof = 1; bit_en = be_on_sof; din_vld = 0;
      @(negedge clk);
      line_sof = 0; n = 0;
      for (int c = 0; c < 8000 && !found; c++) begin
         bit_en = ((c % gap) == 0);
         @(posedge clk);
         if (bit_en) n++;
         @(negedge clk);
         if (pcm_sof) found = 1;
      end
      bit_en = 0;
      if (!found) n = -1;
      @(negedge clk);
      wide = pcm_sof;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n, w, rk, bad, k;
      logic refb [0:511];
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk(pcm_sof == 0, "R1 pcm_sof", pcm_sof, 0);
      chk(dout_vld == 0, "R1 dout_vld", dout_vld, 0);
      chk(dout == 1, "R1 dout", dout, 1);
      chk(ovf_flag == 0 && udf_flag == 0, "R1 flags", {ovf_flag, udf_flag}, 0);

      // R2 R3 R4 table walk
      for (int v = 0; v < NV; v++) begin
         measure(VEC_WL[v], VEC_GAP[v], 1'b0, n, w);
         chk(n == VEC_EXP[v], (VEC_WL[v] == 0) ? "R3 zero delay" : "R2 R4 delay", n, VEC_EXP[v]);
         chk(w == 0, "R5 pulse width", w, 0);
      end

      // R4 R5 restart mid-count, with bit_en on the restart strobe
      set_wl(9);
      @(negedge clk); line_sof = 1; bit_en = 0;
      @(negedge clk); line_sof = 0;
      bad = 0;
      for (int c = 0; c < 5; c++) begin
         bit_en = 1;
         @(negedge clk);
         if (pcm_sof) bad++;
      end
      chk(bad == 0, "R5 no early pulse", bad, 0);
      measure(9, 1, 1'b1, n, w);
      chk(n == 10, "R5 restart delay", n, 10);

      // R6 ordered stream
      do_reset();
      set_wl(20);
      @(negedge clk); line_sof = 1; bit_en = 0; din_vld = 0;
      rk = 0; bad = 0;
      for (int c = 0; c < 300; c++) begin
         @(negedge clk);
         line_sof = 0;
         if (dout_vld) begin
            if (dout !== refb[rk]) bad++;
            rk++;
         end
         bit_en = 1; din_vld = 1; din = pat(c + 7);
         refb[c] = din;
      end
      @(negedge clk);
      bit_en = 0; din_vld = 0;
      chk(bad == 0, "R6 order", bad, 0);
      chk(rk >= 270, "R6 read count", rk, 270);
      chk(ovf_flag == 0 && udf_flag == 0, "R6 no flags", {ovf_flag, udf_flag}, 0);

      // R7 R8 R10 fill to the ceiling with reads held off
      do_reset();
      bad = 0;
      for (int i = 0; i < 190; i++) begin
         @(negedge clk);
         if (dout_vld) bad++;
         bit_en = 1; din_vld = 1; din = pat(i);
         ovf_clr = (i == 188);
      end
      @(negedge clk);
      bit_en = 0; din_vld = 0; ovf_clr = 0;
      chk(bad == 0, "R10 no early read", bad, 0);
      chk(ovf_flag == 1, "R8 set wins over clear", ovf_flag, 1);
      ovf_clr = 1;
      @(negedge clk);
      ovf_clr = 0;
      chk(ovf_flag == 0, "R8 cleared", ovf_flag, 0);
      chk(udf_flag == 0, "R9 no false underflow", udf_flag, 0);

      // R6 R7 R9 drain
      set_wl(0);
      line_sof = 1;
      @(negedge clk);
      line_sof = 0;
      k = 0; bad = 0;
      for (int c = 0; c < 200; c++) begin
         bit_en = 1;
         @(negedge clk);
         if (dout_vld) begin
            if (k < 185) begin
               if (dout !== pat(k)) bad++;
            end else if (dout !== 1'b1) bad++;
            if (k == 184) chk(udf_flag == 0, "R9 not yet empty", udf_flag, 0);
            k++;
         end
      end
      bit_en = 0;
      chk(bad == 0, "R7 kept bits and R9 fill", bad, 0);
      chk(k > 185, "R9 reads past empty", k, 186);
      chk(udf_flag == 1, "R9 underflow flag", udf_flag, 1);
      chk(ovf_flag == 0, "R8 stays clear", ovf_flag, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule